// File: doc/BRIEF.md
# Asynchronous FIFO Bus Master Sequencer

This block drives the external-master side of a strobe-based asynchronous FIFO bus from a clocked system. A command arrives on a valid/ready request port and carries a direction, a FIFO address, a byte count and a commit flag. The sequencer places the address and chip-select on the bus and lets them settle for a setup interval. For a read it lowers output-enable and then pulses the read strobe once per byte. For a write it pulses the write strobe once per byte, with data driven onto the bus. Before every byte it checks the full flag (writes) or the empty flag (reads) and stalls while that flag forbids the transfer.

Every strobe phase is timed by a cycle counter against its own parameter: setup, strobe low, strobe high, packet-commit low, packet-commit high and address hold. For reads, the byte on the bus is captured a programmable number of cycles into the strobe so that the FIFO's output delay is covered. A write with the commit flag set ends with a packet-commit pulse, which is issued only after the last write strobe has spent its full inactive time. A one-cycle done pulse marks the return to idle.

Top module: `afifo_bus_master`

## Requirements
- R1: After reset all strobes, chip-select and output-enable are high (inactive), `req_ready` is high and `done` is low. `req_ready` is high only while no command is in progress. A command is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_len` holds the byte count minus one.
- R2: `bus_addr` and `bus_cs_n` change on the edge that accepts a command. The address stays constant while `bus_cs_n` is low. The first read or write strobe falls no earlier than `T_SETUP` cycles after `bus_cs_n` falls.
- R3: After the last strobe or packet-commit pulse rises, `bus_cs_n` and `bus_addr` are held for at least `T_HOLD` more cycles before `bus_cs_n` rises.
- R4: Every read or write strobe stays low for exactly `T_LOW` cycles. Between two strobes of one command, both strobes stay high for at least `T_HIGH` cycles.
- R5: For a read, `bus_oe_n` falls together with `bus_cs_n` and stays low until the command ends. `bus_rd_n` is low only while `bus_oe_n` and `bus_cs_n` are low. Exactly one read strobe is issued per byte.
- R6: For each read strobe, `bus_din` is captured at the edge that ends strobe-low cycle number `T_SAMPLE`+1 (cycles counted from 1). The captured byte appears on `rd_data` with a one-cycle `rd_valid` pulse.
- R7: For a write, `wr_next` pulses once per byte, on the cycle the write strobe falls. The byte on `wr_byte` at that edge is driven on `bus_dout` with `bus_dout_en` high. It stays unchanged through the strobe-low time and the following `T_HIGH` cycles, so it is the value present when `bus_wr_n` rises.
- R8: No read strobe falls unless `fifo_empty` was low in the cycle before, and no write strobe falls unless `fifo_full` was low in the cycle before. While the flag stays high the sequencer waits with chip-select held and issues no strobe.
- R9: When a write has its commit flag set, `bus_commit_n` pulses low once after the last write strobe. The pulse starts no earlier than `T_HIGH` cycles after `bus_wr_n` rises and never overlaps a write strobe. It lasts exactly `T_PE_LOW` cycles and is followed by at least `T_PE_HIGH` high cycles before chip-select rises. The commit flag is ignored on reads: no pulse is issued.
- R10: `done` is a single-cycle pulse, issued once per command, in the cycle where `bus_cs_n` returns high and `req_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Sequencer idle, command can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | FIFO address for the command |
| req_len | input | LENW | Byte count minus one |
| req_commit | input | 1 | Issue a packet-commit pulse after a write |
| wr_byte | input | DW | Next byte to write |
| wr_next | output | 1 | Pulse: `wr_byte` was taken |
| rd_data | output | DW | Last byte read |
| rd_valid | output | 1 | Pulse: `rd_data` is new |
| done | output | 1 | Pulse: command finished |
| fifo_full | input | 1 | FIFO full flag, blocks writes |
| fifo_empty | input | 1 | FIFO empty flag, blocks reads |
| bus_addr | output | AW | FIFO address lines |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_oe_n | output | 1 | Output-enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_commit_n | output | 1 | Packet-commit strobe, active low |
| bus_dout | output | DW | Write data toward the FIFO |
| bus_dout_en | output | 1 | Write data driver enable |
| bus_din | input | DW | Read data from the FIFO |

## Verification
The bound checker checks the following on every cycle:
- read and write strobes never overlap, and the commit strobe never overlaps the write strobe;
- the address is stable under chip-select;
- output-enable covers every read strobe and stays low across a burst;
- strobe-low widths are exact and commit starts only after the write-high time;
- the blocking flag was clear on the cycle before each strobe falls;
- write data is stable while the write strobe is low.

Only the bench scenarios can show the rest: that the right bytes reach the bus and come back in the right order, and that reads are sampled at the programmed point in the strobe. They also show that stalls under a held flag really issue no strobe, that commit is ignored on reads, and that exactly one done pulse, one strobe per byte and the setup and hold spacing occur per command.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FLAG,
        ST_STROBE,
        ST_RECOV,
        ST_PE_LOW,
        ST_PE_HIGH,
        ST_HOLD
    } seq_state_e;

endpackage

// File: rtl/afifo_phase_timer.sv
// Down-counter timing one bus phase: loaded with (cycles - 1), reaches zero
// in the last cycle of the phase.
module afifo_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/afifo_rd_capture.sv
// Registers the read bus on the sample cycle and flags it for one cycle.
module afifo_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    logic [DW-1:0] data_d, data_q;
    logic          vld_d, vld_q;

    always_comb begin
        data_d = data_q;
        vld_d  = sample;
        if (sample) begin
            data_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rd_data  = data_q;
    assign rd_valid = vld_q;

endmodule

// File: rtl/afifo_seq_fsm.sv
// Phase sequencer: walks setup, flag check, strobe, recovery, optional
// commit pulse and hold; all bus controls are registered from the next state.
module afifo_seq_fsm
    import afifo_pkg::*;
#(
    parameter int AW        = 2,
    parameter int DW        = 8,
    parameter int LENW      = 8,
    parameter int CW        = 4,
    parameter int T_SETUP   = 2,
    parameter int T_LOW     = 3,
    parameter int T_HIGH    = 2,
    parameter int T_HOLD    = 1,
    parameter int T_PE_LOW  = 2,
    parameter int T_PE_HIGH = 2,
    parameter int T_SAMPLE  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [LENW-1:0] req_len,
    input  logic            req_commit,
    output logic            req_ready,
    input  logic [DW-1:0]   wr_byte,
    input  logic            fifo_full,
    input  logic            fifo_empty,
    input  logic [CW-1:0]   tmr_count,
    output logic            tmr_load,
    output logic [CW-1:0]   tmr_val,
    output logic            rd_sample,
    output logic            wr_next,
    output logic            done,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_cs_n,
    output logic            bus_oe_n,
    output logic            bus_rd_n,
    output logic            bus_wr_n,
    output logic            bus_commit_n,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_dout_en
);

    localparam logic [CW-1:0] SETUP_M1 = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] LOW_M1   = CW'(T_LOW - 1);
    localparam logic [CW-1:0] HIGH_M1  = CW'(T_HIGH - 1);
    localparam logic [CW-1:0] HOLD_M1  = CW'(T_HOLD - 1);
    localparam logic [CW-1:0] PEL_M1   = CW'(T_PE_LOW - 1);
    localparam logic [CW-1:0] PEH_M1   = CW'(T_PE_HIGH - 1);
    localparam logic [CW-1:0] SMP_CNT  = CW'(T_LOW - 1 - T_SAMPLE);

    typedef struct packed {
        seq_state_e      st;
        logic            write;
        logic            commit;
        logic [AW-1:0]   addr;
        logic [LENW-1:0] rem;
        logic [DW-1:0]   dout;
        logic            drv;
        logic            cs_n;
        logic            oe_n;
        logic            rd_n;
        logic            wr_n;
        logic            pe_n;
        logic            wr_next;
        logic            done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, write: 1'b0, commit: 1'b0, addr: '0, rem: '0,
        dout: '0, drv: 1'b0, cs_n: 1'b1, oe_n: 1'b1, rd_n: 1'b1,
        wr_n: 1'b1, pe_n: 1'b1, wr_next: 1'b0, done: 1'b0
    };

    seq_t d, q;
    logic expired;
    logic blocked;

    always_comb begin
        d         = q;
        d.wr_next = 1'b0;
        d.done    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        expired   = (tmr_count == '0);
        blocked   = q.write ? fifo_full : fifo_empty;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_SETUP;
                    d.write  = req_write;
                    d.commit = req_commit & req_write;
                    d.addr   = req_addr;
                    d.rem    = req_len;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_M1;
                end
            end
            ST_SETUP: begin
                if (expired) d.st = ST_FLAG;
            end
            ST_FLAG: begin
                if (!blocked) begin
                    d.st     = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = LOW_M1;
                    if (q.write) begin
                        d.dout    = wr_byte;
                        d.drv     = 1'b1;
                        d.wr_next = 1'b1;
                    end
                end
            end
            ST_STROBE: begin
                if (expired) begin
                    d.st     = ST_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = HIGH_M1;
                end
            end
            ST_RECOV: begin
                if (expired) begin
                    tmr_load = 1'b1;
                    if (q.rem != '0) begin
                        d.rem = q.rem - 1'b1;
                        d.st  = ST_FLAG;
                    end else if (q.commit) begin
                        d.st    = ST_PE_LOW;
                        tmr_val = PEL_M1;
                    end else begin
                        d.st    = ST_HOLD;
                        tmr_val = HOLD_M1;
                    end
                end
            end
            ST_PE_LOW: begin
                if (expired) begin
                    d.st     = ST_PE_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = PEH_M1;
                end
            end
            ST_PE_HIGH: begin
                if (expired) begin
                    d.st     = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_M1;
                end
            end
            ST_HOLD: begin
                if (expired) begin
                    d.st   = ST_IDLE;
                    d.drv  = 1'b0;
                    d.done = 1'b1;
                end
            end
            default: d = SEQ_RST;
        endcase

        // Bus controls follow the next state so they leave a flop directly.
        d.cs_n = (d.st == ST_IDLE);
        d.oe_n = (d.st == ST_IDLE) || d.write;
        d.rd_n = !((d.st == ST_STROBE) && !d.write);
        d.wr_n = !((d.st == ST_STROBE) && d.write);
        d.pe_n = (d.st != ST_PE_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign rd_sample    = (q.st == ST_STROBE) && !q.write && (tmr_count == SMP_CNT);
    assign wr_next      = q.wr_next;
    assign done         = q.done;
    assign bus_addr     = q.addr;
    assign bus_cs_n     = q.cs_n;
    assign bus_oe_n     = q.oe_n;
    assign bus_rd_n     = q.rd_n;
    assign bus_wr_n     = q.wr_n;
    assign bus_commit_n = q.pe_n;
    assign bus_dout     = q.dout;
    assign bus_dout_en  = q.drv;

endmodule

// File: rtl/afifo_bus_master.sv
module afifo_bus_master #(
    parameter int AW        = 2,
    parameter int DW        = 8,
    parameter int LENW      = 8,
    parameter int CW        = 4,
    parameter int T_SETUP   = 2,
    parameter int T_LOW     = 3,
    parameter int T_HIGH    = 2,
    parameter int T_HOLD    = 1,
    parameter int T_PE_LOW  = 2,
    parameter int T_PE_HIGH = 2,
    parameter int T_SAMPLE  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [LENW-1:0] req_len,
    input  logic            req_commit,
    input  logic [DW-1:0]   wr_byte,
    output logic            wr_next,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic            done,
    input  logic            fifo_full,
    input  logic            fifo_empty,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_cs_n,
    output logic            bus_oe_n,
    output logic            bus_rd_n,
    output logic            bus_wr_n,
    output logic            bus_commit_n,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_dout_en,
    input  logic [DW-1:0]   bus_din
);

    if (T_SAMPLE >= T_LOW || T_SETUP < 1 || T_LOW < 1 || T_HIGH < 1 ||
        T_HOLD < 1 || T_PE_LOW < 1 || T_PE_HIGH < 1) begin : g_bad_timing
        $error("afifo_bus_master: phase widths must be >= 1 and T_SAMPLE < T_LOW");
    end

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] tmr_count;
    logic          rd_sample;

    afifo_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_count)
    );

    afifo_seq_fsm #(
        .AW(AW), .DW(DW), .LENW(LENW), .CW(CW),
        .T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_HOLD(T_HOLD),
        .T_PE_LOW(T_PE_LOW), .T_PE_HIGH(T_PE_HIGH), .T_SAMPLE(T_SAMPLE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_commit   (req_commit),
        .req_ready    (req_ready),
        .wr_byte      (wr_byte),
        .fifo_full    (fifo_full),
        .fifo_empty   (fifo_empty),
        .tmr_count    (tmr_count),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .rd_sample    (rd_sample),
        .wr_next      (wr_next),
        .done         (done),
        .bus_addr     (bus_addr),
        .bus_cs_n     (bus_cs_n),
        .bus_oe_n     (bus_oe_n),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .bus_commit_n (bus_commit_n),
        .bus_dout     (bus_dout),
        .bus_dout_en  (bus_dout_en)
    );

    afifo_rd_capture #(.DW(DW)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (rd_sample),
        .din      (bus_din),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/afifo_bus_master_chk.sv
module afifo_bus_master_chk #(
    parameter int AW       = 2,
    parameter int DW       = 8,
    parameter int T_LOW    = 3,
    parameter int T_HIGH   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic [AW-1:0] bus_addr,
    input logic          bus_cs_n,
    input logic          bus_oe_n,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic          bus_commit_n,
    input logic [DW-1:0] bus_dout,
    input logic          bus_dout_en
);

    logic       strb_hi;
    logic [7:0] lo_cnt_q;
    logic [7:0] wr_hi_q;

    assign strb_hi = bus_rd_n && bus_wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            wr_hi_q  <= '0;
        end else begin
            lo_cnt_q <= strb_hi ? 8'd0 : ((lo_cnt_q == 8'hff) ? lo_cnt_q : lo_cnt_q + 8'd1);
            wr_hi_q  <= !bus_wr_n ? 8'd0 : ((wr_hi_q == 8'hff) ? wr_hi_q : wr_hi_q + 8'd1);
        end
    end

    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_cs_n);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_hi && !$past(strb_hi)) |-> (lo_cnt_q == 8'(T_LOW)));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    p_oe_covers_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!bus_oe_n && !bus_cs_n));

    p_oe_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n) && $past(!bus_oe_n)) |-> !bus_oe_n);

    p_wdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_dout) && bus_dout_en));

    p_full_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> !$past(fifo_full));

    p_empty_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> !$past(fifo_empty));

    p_commit_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_commit_n) |-> (bus_wr_n && (wr_hi_q >= 8'(T_HIGH))));

    p_commit_no_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_commit_n && !bus_wr_n));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind afifo_bus_master afifo_bus_master_chk #(
    .AW(AW), .DW(DW), .T_LOW(T_LOW), .T_HIGH(T_HIGH)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .done         (done),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .bus_addr     (bus_addr),
    .bus_cs_n     (bus_cs_n),
    .bus_oe_n     (bus_oe_n),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_commit_n (bus_commit_n),
    .bus_dout     (bus_dout),
    .bus_dout_en  (bus_dout_en)
);

// File: tb/test_afifo_bus_master.sv
`timescale 1ns/1ps
module test_afifo_bus_master;

    localparam int AW = 2, DW = 8, LENW = 8, CW = 4;
    localparam int T_SETUP = 2, T_LOW = 3, T_HIGH = 2, T_HOLD = 1;
    localparam int T_PE_LOW = 2, T_PE_HIGH = 2, T_SAMPLE = 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n;
    logic            req_valid, req_ready, req_write, req_commit;
    logic [AW-1:0]   req_addr;
    logic [LENW-1:0] req_len;
    logic [DW-1:0]   wr_byte, rd_data, bus_dout, bus_din;
    logic            wr_next, rd_valid, done;
    logic            fifo_full, fifo_empty;
    logic [AW-1:0]   bus_addr;
    logic            bus_cs_n, bus_oe_n, bus_rd_n, bus_wr_n, bus_commit_n, bus_dout_en;

    afifo_bus_master #(
        .AW(AW), .DW(DW), .LENW(LENW), .CW(CW),
        .T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_HOLD(T_HOLD),
        .T_PE_LOW(T_PE_LOW), .T_PE_HIGH(T_PE_HIGH), .T_SAMPLE(T_SAMPLE)
    ) i_afifo_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_commit(req_commit), .wr_byte(wr_byte), .wr_next(wr_next),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_commit_n(bus_commit_n), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din)
    );

    int vectors = 0;
    int errors  = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // FIFO-side data models
    logic [DW-1:0] wbuf [256];
    logic [DW-1:0] rbuf [256];
    int widx = 0, wcap = 0, rptr = 0, rcap = 0;
    int rd_lowcnt = 0;

    assign wr_byte = wbuf[widx[7:0]];
    always @(posedge clk) rd_lowcnt <= !bus_rd_n ? rd_lowcnt + 1 : 0;
    // valid data only once the FIFO output delay (T_SAMPLE cycles) has passed
    assign bus_din = (!bus_rd_n && rd_lowcnt >= T_SAMPLE) ? rbuf[rptr[7:0]] : ~rbuf[rptr[7:0]];

    // flag drivers, updated just after each rising edge
    bit   rnd_flags = 1'b0;
    logic hold_full = 1'b0, hold_empty = 1'b0;
    initial begin
        fifo_full  = 1'b0;
        fifo_empty = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            fifo_full  = rnd_flags ? ($urandom_range(0, 3) == 0) : hold_full;
            fifo_empty = rnd_flags ? ($urandom_range(0, 3) == 0) : hold_empty;
        end
    end

    // bus monitor
    logic p_rd = 1'b1, p_wr = 1'b1, p_pe = 1'b1, p_cs = 1'b1;
    logic p_full = 1'b0, p_empty = 1'b0;
    logic [AW-1:0] p_addr = '0;
    int rd_lo = 0, wr_lo = 0, pe_lo = 0, pe_hi = 0, st_hi = 0, cs_lo = 0, since_end = 0;
    bit seen_strobe = 1'b0, addr_moved = 1'b0;
    int n_rd = 0, n_wr = 0, n_pe = 0, n_done = 0, n_rv = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_rd_n && p_rd) begin
                chk(!bus_oe_n && !bus_cs_n, "R5 oe/cs low at read strobe", bus_oe_n, 0);
                chk(!p_empty, "R8 empty clear before read strobe", p_empty, 0);
                if (!seen_strobe) chk(cs_lo >= T_SETUP, "R2 setup before strobe", cs_lo, T_SETUP);
                else chk(st_hi >= T_HIGH, "R4 strobe high width", st_hi, T_HIGH);
                seen_strobe = 1'b1;
            end
            if (!bus_wr_n && p_wr) begin
                chk(!p_full, "R8 full clear before write strobe", p_full, 0);
                if (!seen_strobe) chk(cs_lo >= T_SETUP, "R2 setup before strobe", cs_lo, T_SETUP);
                else chk(st_hi >= T_HIGH, "R4 strobe high width", st_hi, T_HIGH);
                seen_strobe = 1'b1;
            end
            if (bus_rd_n && !p_rd) begin
                chk(rd_lo == T_LOW, "R4 read strobe low width", rd_lo, T_LOW);
                rptr++;
                n_rd++;
            end
            if (bus_wr_n && !p_wr) begin
                chk(wr_lo == T_LOW, "R4 write strobe low width", wr_lo, T_LOW);
                chk(bus_dout_en && bus_dout == wbuf[wcap[7:0]], "R7 write data at strobe rise",
                    int'(bus_dout), int'(wbuf[wcap[7:0]]));
                wcap++;
                n_wr++;
            end
            if (!bus_commit_n && p_pe) begin
                chk(bus_wr_n && st_hi >= T_HIGH, "R9 commit after write high time", st_hi, T_HIGH);
            end
            if (bus_commit_n && !p_pe) begin
                chk(pe_lo == T_PE_LOW, "R9 commit low width", pe_lo, T_PE_LOW);
                n_pe++;
            end
            if (bus_cs_n && !p_cs) begin
                chk(!addr_moved, "R2 address stable under chip-select", int'(addr_moved), 0);
                chk(since_end >= T_HOLD, "R3 hold after last strobe", since_end, T_HOLD);
                if (n_pe > 0) chk(pe_hi >= T_PE_HIGH, "R9 commit high before release", pe_hi, T_PE_HIGH);
                seen_strobe = 1'b0;
                addr_moved  = 1'b0;
            end
            if (!bus_cs_n && !p_cs && bus_addr != p_addr) addr_moved = 1'b1;
            if (rd_valid) begin
                chk(rd_data == rbuf[rcap[7:0]], "R6 read data captured",
                    int'(rd_data), int'(rbuf[rcap[7:0]]));
                rcap++;
                n_rv++;
            end
            if (wr_next) widx++;
            if (done) begin
                n_done++;
                chk(bus_cs_n && req_ready, "R10 done with idle bus", int'(bus_cs_n), 1);
            end
            rd_lo     = !bus_rd_n ? rd_lo + 1 : 0;
            wr_lo     = !bus_wr_n ? wr_lo + 1 : 0;
            pe_lo     = !bus_commit_n ? pe_lo + 1 : 0;
            pe_hi     = bus_commit_n ? pe_hi + 1 : 0;
            st_hi     = (bus_rd_n && bus_wr_n) ? st_hi + 1 : 0;
            cs_lo     = !bus_cs_n ? cs_lo + 1 : 0;
            since_end = (bus_rd_n && bus_wr_n && bus_commit_n) ? since_end + 1 : 0;
        end
        p_rd = bus_rd_n; p_wr = bus_wr_n; p_pe = bus_commit_n; p_cs = bus_cs_n;
        p_addr = bus_addr; p_full = fifo_full; p_empty = fifo_empty;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    task automatic run_cmd(bit w, logic [AW-1:0] a, int nb, bit cm);
        int t;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        n_rd = 0; n_wr = 0; n_pe = 0; n_done = 0; n_rv = 0;
        widx = 0; wcap = 0; rptr = 0; rcap = 0;
        for (int i = 0; i < nb; i++) begin
            wbuf[i] = 8'($urandom);
            rbuf[i] = 8'($urandom);
        end
        req_valid = 1'b1; req_write = w; req_addr = a;
        req_len = LENW'(nb - 1); req_commit = cm;
        @(negedge clk);
        #1;
        req_valid = 1'b0;
        chk(!req_ready, "R1 ready drops after accept", int'(req_ready), 0);
        t = 0;
        while (n_done == 0 && t < 3000) begin
            @(negedge clk);
            #1;
            t++;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(n_done == 1, "R10 one done per command", n_done, 1);
        if (w) begin
            chk(n_wr == nb && wcap == nb, "R7 one write strobe per byte", n_wr, nb);
            chk(widx == nb, "R7 one wr_next per byte", widx, nb);
        end else begin
            chk(n_rd == nb, "R5 one read strobe per byte", n_rd, nb);
            chk(n_rv == nb, "R6 one captured byte per strobe", n_rv, nb);
        end
        chk(n_pe == ((w && cm) ? 1 : 0), "R9 commit pulse count", n_pe, (w && cm) ? 1 : 0);
    endtask

    task automatic stall_probe(bit w);
        repeat (20) @(negedge clk);
        #1;
        chk(!bus_cs_n && bus_rd_n && bus_wr_n && n_rd == 0 && n_wr == 0,
            "R8 no strobe while flag blocks", n_rd + n_wr, 0);
        if (w) hold_full = 1'b0;
        else   hold_empty = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e_3d4c));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_len = '0; req_commit = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(bus_cs_n && bus_oe_n && bus_rd_n && bus_wr_n && bus_commit_n,
            "R1 strobes inactive in reset", int'(bus_cs_n), 1);
        chk(req_ready && !done && !bus_dout_en, "R1 ready, no done after reset", int'(req_ready), 1);
        rst_n = 1'b1;

        run_cmd(1'b0, 2'd1, 1, 1'b0);   // single read
        run_cmd(1'b1, 2'd2, 1, 1'b0);   // single write
        run_cmd(1'b1, 2'd3, 4, 1'b1);   // short packet committed
        run_cmd(1'b0, 2'd0, 4, 1'b1);   // R9: commit ignored on read
        run_cmd(1'b0, 2'd2, 20, 1'b0);  // long read burst
        run_cmd(1'b1, 2'd1, 20, 1'b1);  // long write burst with commit

        // R8: held flags stall the first byte
        hold_full = 1'b1;
        fork
            run_cmd(1'b1, 2'd1, 3, 1'b0);
            stall_probe(1'b1);
        join
        hold_empty = 1'b1;
        fork
            run_cmd(1'b0, 2'd3, 3, 1'b0);
            stall_probe(1'b0);
        join

        // random traffic with random flag stalls
        rnd_flags = 1'b1;
        for (int k = 0; k < 40; k++) begin
            run_cmd(1'($urandom_range(0, 1)), AW'($urandom), $urandom_range(1, 12),
                    1'($urandom_range(0, 1)));
        end
        rnd_flags = 1'b0;

        summary();
        $finish;
    end

endmodule